// File: doc/BRIEF.md
# Flash Cell Array Model with Injectable Faults

This block is a small synthesizable behavioural model of a NOR-style flash array. Its cells are arranged as rows, which stand for word-lines, and columns, which stand for bit-lines. The model accepts three commands: erase the whole array, program one bit, and read one bit. Each accepted command keeps the block busy for a number of clock cycles. That number is given separately for each command, so slow erases and fast reads can be modelled on a compressed time scale.

A set of fault-configuration inputs places one functional fault at a time in the array. The fault has a victim cell and, where the fault needs one, an aggressor cell. The fault kinds are:

- stuck-at-0 and stuck-at-1;
- the four disturb faults between cells that share a word-line or a bit-line;
- read disturb;
- over-erase.

The model is intended as the memory under test for a March-style built-in self-test engine. That engine drives the command port and compares the read data against expected values.

Top module: `flash_fault_array`

## Requirements
- R1: After reset, `busy` is 0, `rd_data` is 0, and every cell holds 1.
- R2: A command is accepted when `cmd_valid` is 1, `busy` is 0 and `cmd_op` is not 0. The opcodes are 1 for erase, 2 for program and 3 for read. An accepted erase sets every cell to 1.
- R3: An accepted program clears only the addressed cell to 0. No command other than erase, or a fault that injects a 1, ever changes a cell from 0 to 1.
- R4: After an accepted command, `busy` is 1 for exactly N cycles. N is `erase_cycles`, `prog_cycles` or `read_cycles` for that command, and a count of 0 behaves as 1. `rd_data` carries the read value in the cycle `busy` falls and holds it until the next accepted read.
- R5: A command presented while `busy` is 1 is ignored. It does not change the cells, `rd_data` or the busy duration.
- R6: Fault codes are 0 for stuck-at-0 and 1 for stuck-at-1. With either one enabled, a read of the victim returns the stuck value whatever the cell stores.
- R7: With code 2 (word-line program disturb), a program of the aggressor that changes it from 1 to 0 clears a victim that holds 1. With code 3 (word-line erase disturb), the same event sets a victim that holds 0. Both act only when the victim and the aggressor share a row.
- R8: Codes 4 (bit-line program disturb) and 5 (bit-line erase disturb) behave like codes 2 and 3, but act only when the victim and the aggressor share a column.
- R9: With code 6 (read disturb), a read of the victim while it holds 0 returns 0 and then leaves the victim at 1.
- R10: With code 7 (over-erase), a program of the victim leaves it at 1. A read of any other row in the victim's column returns 1.
- R11: With `flt_en` at 0, no fault has any effect. A disturb fault does not fire when the aggressor already holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 1 erase, 2 program, 3 read |
| cmd_row | input | ROW_W | Row (word-line) address |
| cmd_col | input | COL_W | Column (bit-line) address |
| erase_cycles | input | CNT_W | Busy length of erase |
| prog_cycles | input | CNT_W | Busy length of program |
| read_cycles | input | CNT_W | Busy length of read |
| flt_en | input | 1 | Fault enable |
| flt_kind | input | 3 | Fault code (see R6 to R10) |
| flt_vrow | input | ROW_W | Victim row |
| flt_vcol | input | COL_W | Victim column |
| flt_arow | input | ROW_W | Aggressor row |
| flt_acol | input | COL_W | Aggressor column |
| busy | output | 1 | Command in progress |
| rd_data | output | 1 | Last read value |

## Verification
A wrong cell state does not show at the ports until that cell is read. The earliest point is therefore the fall of `busy` on the next read of that address, so each scenario reads back the victim and its neighbours right after the triggering command. A wrong busy counter shows within the command itself, because the high period of `busy` then differs from the configured count. A lost or extra acceptance shows as a changed read-back value after the ignored command.

// File: rtl/flash_fault_pkg.sv
// Shared encodings for the flash array model: command opcodes and fault codes.
package flash_fault_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROG  = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        FK_SA0 = 3'd0,
        FK_SA1 = 3'd1,
        FK_WLP = 3'd2,
        FK_WLE = 3'd3,
        FK_BLP = 3'd4,
        FK_BLE = 3'd5,
        FK_RDD = 3'd6,
        FK_OVE = 3'd7
    } fault_e;
endpackage

// File: rtl/ffa_busy_timer.sv
// Busy timer: holds busy high for exactly `len` cycles after a start pulse.
// Assumes start is only pulsed while busy is low; len of 0 counts as 1.
module ffa_busy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             busy
);
    logic [CNT_W-1:0] remain;

    // Load the remaining count on start, count down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= (len == '0) ? '0 : len - 1'b1;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    a_r5_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
endmodule

// File: rtl/ffa_cell_array.sv
// Cell storage: one flip-flop per cell, reset and erase to 1.
// Program clears a single cell; victim set/clear requests from the fault
// unit take precedence over a program of the same cell.
module ffa_cell_array #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int CELLS = ROWS * COLS,
    localparam int IDX_W = $clog2(CELLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             erase,
    input  logic             prog,
    input  logic [IDX_W-1:0] prog_idx,
    input  logic             vset,
    input  logic             vclr,
    input  logic [IDX_W-1:0] vidx,
    output logic [CELLS-1:0] cells
);
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        // Next state of cell i from erase, fault injection and program.
        always_ff @(posedge clk) begin
            if (!rst_n)                                cells[i] <= 1'b1;
            else if (erase)                            cells[i] <= 1'b1;
            else if (vset && vidx == IDX_W'(i))        cells[i] <= 1'b1;
            else if (vclr && vidx == IDX_W'(i))        cells[i] <= 1'b0;
            else if (prog && prog_idx == IDX_W'(i))    cells[i] <= 1'b0;
        end
    end

    a_r2_erase_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (&cells));
    a_r3_prog_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (prog && !erase && !(vset && vidx == prog_idx)) |=> (cells[$past(prog_idx)] == 1'b0));
    a_r3_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!erase && !vset) |=> ((cells & ~$past(cells)) == '0));
endmodule

// File: rtl/ffa_fault_unit.sv
// Fault unit: from the current cell contents, the accepted command and the
// fault configuration, derives victim set/clear requests, the program block
// for an over-erased victim, and the value a read returns.
// Assumes at most one fault is active, selected by kind.
module ffa_fault_unit
    import flash_fault_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int CELLS = ROWS * COLS,
    localparam int IDX_W = $clog2(CELLS),
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic [CELLS-1:0] cells,
    input  logic             is_prog,
    input  logic             is_read,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             en,
    input  logic [2:0]       kind,
    input  logic [ROW_W-1:0] vrow,
    input  logic [COL_W-1:0] vcol,
    input  logic [ROW_W-1:0] arow,
    input  logic [COL_W-1:0] acol,
    output logic [IDX_W-1:0] vidx,
    output logic             vset,
    output logic             vclr,
    output logic             prog_block,
    output logic             rd_bit
);
    fault_e           fk;
    logic [IDX_W-1:0] cidx;
    logic             cur_bit, vbit;
    logic             at_victim, at_aggr, aggr_fall, same_row, same_col;

    // Address decode and aggressor event detection.
    always_comb begin
        fk        = fault_e'(kind);
        cidx      = IDX_W'(row) * IDX_W'(COLS) + IDX_W'(col);
        vidx      = IDX_W'(vrow) * IDX_W'(COLS) + IDX_W'(vcol);
        cur_bit   = cells[cidx];
        vbit      = cells[vidx];
        at_victim = (row == vrow) && (col == vcol);
        at_aggr   = (row == arow) && (col == acol);
        same_row  = (arow == vrow) && (acol != vcol);
        same_col  = (acol == vcol) && (arow != vrow);
        aggr_fall = en && is_prog && at_aggr && cur_bit;
    end

    // Victim set/clear requests for disturb and read-disturb faults.
    always_comb begin
        vset = 1'b0;
        vclr = 1'b0;
        unique case (fk)
            FK_WLP:  vclr = aggr_fall && same_row && vbit;
            FK_WLE:  vset = aggr_fall && same_row && !vbit;
            FK_BLP:  vclr = aggr_fall && same_col && vbit;
            FK_BLE:  vset = aggr_fall && same_col && !vbit;
            FK_RDD:  vset = en && is_read && at_victim && !vbit;
            default: ;
        endcase
    end

    // Program block for the over-erased victim.
    always_comb prog_block = en && is_prog && at_victim && (fk == FK_OVE);

    // Value returned by a read, with stuck-at and leakage overrides.
    always_comb begin
        rd_bit = cur_bit;
        if (en && at_victim && fk == FK_SA0)                   rd_bit = 1'b0;
        else if (en && at_victim && fk == FK_SA1)              rd_bit = 1'b1;
        else if (en && fk == FK_OVE && col == vcol && row != vrow) rd_bit = 1'b1;
    end
endmodule

// File: rtl/flash_fault_array.sv
// Top: flash array model with command decode, per-command busy timing,
// fault unit and cell storage. A command is taken only while idle; its
// effect on the cells and the read value are registered at acceptance.
module flash_fault_array
    import flash_fault_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    parameter int CNT_W = 16,
    localparam int CELLS = ROWS * COLS,
    localparam int IDX_W = $clog2(CELLS),
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [ROW_W-1:0] cmd_row,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [CNT_W-1:0] erase_cycles,
    input  logic [CNT_W-1:0] prog_cycles,
    input  logic [CNT_W-1:0] read_cycles,
    input  logic             flt_en,
    input  logic [2:0]       flt_kind,
    input  logic [ROW_W-1:0] flt_vrow,
    input  logic [COL_W-1:0] flt_vcol,
    input  logic [ROW_W-1:0] flt_arow,
    input  logic [COL_W-1:0] flt_acol,
    output logic             busy,
    output logic             rd_data
);
    op_e              op;
    logic             accept, is_erase, is_prog, is_read;
    logic [CNT_W-1:0] len;
    logic [IDX_W-1:0] cidx, vidx;
    logic             vset, vclr, prog_block, rd_bit;
    logic [CELLS-1:0] cells;

    // Command decode and busy length selection.
    always_comb begin
        op       = op_e'(cmd_op);
        accept   = cmd_valid && !busy && (op != OP_NONE);
        is_erase = accept && (op == OP_ERASE);
        is_prog  = accept && (op == OP_PROG);
        is_read  = accept && (op == OP_READ);
        cidx     = IDX_W'(cmd_row) * IDX_W'(COLS) + IDX_W'(cmd_col);
        unique case (op)
            OP_ERASE: len = erase_cycles;
            OP_PROG:  len = prog_cycles;
            default:  len = read_cycles;
        endcase
    end

    ffa_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .len   (len),
        .busy  (busy)
    );

    ffa_fault_unit #(.ROWS(ROWS), .COLS(COLS)) u_fault (
        .cells      (cells),
        .is_prog    (is_prog),
        .is_read    (is_read),
        .row        (cmd_row),
        .col        (cmd_col),
        .en         (flt_en),
        .kind       (flt_kind),
        .vrow       (flt_vrow),
        .vcol       (flt_vcol),
        .arow       (flt_arow),
        .acol       (flt_acol),
        .vidx       (vidx),
        .vset       (vset),
        .vclr       (vclr),
        .prog_block (prog_block),
        .rd_bit     (rd_bit)
    );

    ffa_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_cells (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase    (is_erase),
        .prog     (is_prog && !prog_block),
        .prog_idx (cidx),
        .vset     (vset),
        .vclr     (vclr),
        .vidx     (vidx),
        .cells    (cells)
    );

    // Read data register, updated only by an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= 1'b0;
        else if (is_read) rd_data <= rd_bit;
    end

    a_r4_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> $stable(rd_data));
    a_r5_busy_freezes_cells: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cells));
    a_r6_stuck0_read: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && flt_en && flt_kind == 3'd0 && cmd_row == flt_vrow && cmd_col == flt_vcol)
        |=> (rd_data == 1'b0));
    a_r10_oe_victim_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (is_prog && flt_en && flt_kind == 3'd7 && cmd_row == flt_vrow && cmd_col == flt_vcol)
        |=> (cells[vidx] == $past(cells[vidx])));
endmodule

// File: tb/flash_fault_array_tb.sv
// Directed bench: one task per scenario, each checking its own read-backs.
module flash_fault_array_tb;
    localparam int ROWS = 8, COLS = 8, CNT_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [2:0]  cmd_row = '0, cmd_col = '0;
    logic [CNT_W-1:0] erase_cycles = 16'd7, prog_cycles = 16'd4, read_cycles = 16'd2;
    logic        flt_en = 1'b0;
    logic [2:0]  flt_kind = '0;
    logic [2:0]  flt_vrow = '0, flt_vcol = '0, flt_arow = '0, flt_acol = '0;
    logic        busy, rd_data;

    int total = 0, bad = 0;
    bit finished = 0;

    flash_fault_array #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .erase_cycles(erase_cycles),
        .prog_cycles(prog_cycles), .read_cycles(read_cycles), .flt_en(flt_en),
        .flt_kind(flt_kind), .flt_vrow(flt_vrow), .flt_vcol(flt_vcol),
        .flt_arow(flt_arow), .flt_acol(flt_acol), .busy(busy), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one command at a negedge; return busy length and final rd_data.
    task automatic cmd(input int op, input int r, input int c, output int blen, output logic rd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_row = 3'(r); cmd_col = 3'(c);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
        blen = 0;
        while (busy) begin
            blen++;
            @(negedge clk);
        end
        rd = rd_data;
    endtask

    task automatic erase_all();
        int n; logic d;
        cmd(1, 0, 0, n, d);
    endtask
    task automatic prog(input int r, input int c);
        int n; logic d;
        cmd(2, r, c, n, d);
    endtask
    task automatic rd_chk(input string tag, input int r, input int c, input int exp);
        int n; logic d;
        cmd(3, r, c, n, d);
        chk(tag, int'(d), exp);
    endtask
    task automatic setf(input bit en, input int k, input int vr, input int vc, input int ar, input int ac);
        flt_en = en; flt_kind = 3'(k);
        flt_vrow = 3'(vr); flt_vcol = 3'(vc); flt_arow = 3'(ar); flt_acol = 3'(ac);
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 rd_data after reset", int'(rd_data), 0);
        rd_chk("R1 cell erased at reset", 5, 2, 1);
    endtask

    task automatic t_timing();
        int n; logic d;
        cmd(1, 0, 0, n, d); chk("R4 erase busy length", n, 7);
        cmd(2, 7, 7, n, d); chk("R4 program busy length", n, 4);
        cmd(3, 7, 7, n, d); chk("R4 read busy length", n, 2);
        chk("R4 read data when busy falls", int'(d), 0);
        read_cycles = 16'd0;
        cmd(3, 7, 6, n, d); chk("R4 zero count acts as one", n, 1);
        chk("R4 read data zero-count read", int'(d), 1);
        read_cycles = 16'd2;
        repeat (3) @(negedge clk);
        chk("R4 rd_data holds between reads", int'(rd_data), 1);
    endtask

    task automatic t_program_erase();
        erase_all();
        prog(2, 3);
        rd_chk("R3 programmed cell reads 0", 2, 3, 0);
        rd_chk("R3 row neighbour untouched", 2, 4, 1);
        rd_chk("R3 column neighbour untouched", 3, 3, 1);
        prog(2, 3);
        rd_chk("R3 reprogram keeps 0", 2, 3, 0);
        erase_all();
        rd_chk("R2 erase restores 1", 2, 3, 1);
    endtask

    task automatic t_ignore_busy();
        int n; logic d;
        prog(0, 0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd1;
        @(negedge clk);
        cmd_op = 2'd2; cmd_row = 3'd1; cmd_col = 3'd1;
        n = 0;
        while (busy) begin
            n++;
            if (n > 2) cmd_valid = 1'b0;
            @(negedge clk);
        end
        cmd_valid = 1'b0; cmd_op = 2'd0;
        chk("R5 busy length unchanged", n, 7);
        rd_chk("R5 erase effect kept", 0, 0, 1);
        rd_chk("R5 program during busy ignored", 1, 1, 1);
        cmd(3, 1, 1, n, d);
    endtask

    task automatic t_stuck();
        erase_all();
        setf(1, 0, 1, 1, 0, 0);
        rd_chk("R6 stuck-at-0 victim", 1, 1, 0);
        rd_chk("R6 stuck-at-0 other cell", 1, 2, 1);
        prog(1, 1);
        setf(1, 1, 1, 1, 0, 0);
        rd_chk("R6 stuck-at-1 victim", 1, 1, 1);
        setf(0, 1, 1, 1, 0, 0);
        rd_chk("R11 disabled shows stored value", 1, 1, 0);
    endtask

    task automatic t_wordline();
        erase_all();
        setf(1, 2, 4, 2, 4, 5);
        prog(4, 5);
        rd_chk("R7 program disturb clears victim", 4, 2, 0);
        rd_chk("R7 aggressor programmed", 4, 5, 0);
        erase_all();
        setf(1, 3, 4, 2, 4, 5);
        prog(4, 2);
        prog(4, 5);
        rd_chk("R7 erase disturb sets victim", 4, 2, 1);
        erase_all();
        setf(0, 3, 4, 2, 4, 5);
        prog(4, 2);
        prog(4, 5);
        setf(1, 3, 4, 2, 4, 5);
        prog(4, 5);
        rd_chk("R11 aggressor already 0 no disturb", 4, 2, 0);
    endtask

    task automatic t_bitline();
        erase_all();
        setf(1, 4, 1, 6, 5, 6);
        prog(5, 6);
        rd_chk("R8 bit-line program disturb", 1, 6, 0);
        erase_all();
        setf(1, 5, 1, 6, 5, 6);
        prog(1, 6);
        prog(5, 6);
        rd_chk("R8 bit-line erase disturb", 1, 6, 1);
        erase_all();
        setf(1, 4, 1, 6, 5, 5);
        prog(5, 5);
        rd_chk("R8 other column no disturb", 1, 6, 1);
        erase_all();
        setf(0, 2, 4, 2, 4, 5);
        prog(4, 5);
        rd_chk("R11 disabled disturb no effect", 4, 2, 1);
    endtask

    task automatic t_read_disturb();
        erase_all();
        setf(1, 6, 3, 3, 0, 0);
        prog(3, 3);
        rd_chk("R9 first read returns 0", 3, 3, 0);
        rd_chk("R9 second read returns 1", 3, 3, 1);
    endtask

    task automatic t_over_erase();
        erase_all();
        setf(1, 7, 0, 7, 0, 0);
        prog(0, 7);
        rd_chk("R10 victim cannot be programmed", 0, 7, 1);
        prog(6, 7);
        rd_chk("R10 same column read leaks to 1", 6, 7, 1);
        prog(6, 6);
        rd_chk("R10 other column unaffected", 6, 6, 0);
        setf(0, 7, 0, 7, 0, 0);
        rd_chk("R10 stored value visible when off", 6, 7, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_program_erase();
        t_ignore_busy();
        t_stuck();
        t_wordline();
        t_bitline();
        t_read_disturb();
        t_over_erase();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule